// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block drives the chip-select, output-enable and per-byte write-enable strobes of one asynchronous SRAM bank. It runs on a clock four times the bus rate, so every strobe edge can be placed on a quarter-bus-clock boundary. One tick of this fast clock is one quarter of a bus clock. An access is launched by a one-tick start pulse that carries the direction, byte enables, address, write data and the bank's timing options. The options are a chip-select delay code, an early-negation flag, a 4-bit wait-state count and a relaxed-timing flag. All of these are captured when the access is accepted.

While the access runs, the block holds the address and write data steady and places the strobes according to the captured options. For the whole of the last bus clock of the access it raises a done flag, and then it returns to idle. A start request that arrives during an access is dropped. Tick 0 of an access is the first fast-clock cycle after the edge that accepted the start. All strobes are active-low.

Top module: `sram_strobe_gen`

## Requirements
- R1: With relaxed timing off, every access keeps busy high for exactly 4*(2+S) ticks, where S is the wait-state count.
- R2: The chip-select delay code sets the tick at which chip-select first goes low. Code 2'b00 gives tick 0, 2'b10 gives tick 1, 2'b11 gives tick 2, and the reserved code 2'b01 behaves as 2'b00.
- R3: With relaxed timing on and a delay code of 2'b10 or 2'b11, the chip-select delay grows by 4 ticks, giving tick 5 or tick 6.
- R4: With relaxed timing on, an access lasts 2+2*S bus clocks. One more bus clock is added when the delay code is 2'b10 or 2'b11, and one more again for a write with early negation set.
- R5: On a write with early negation set, the write-enables rise 1 tick before the end of the access, or 5 ticks before it in relaxed mode. Chip-select rises at that same tick when the delay code is 2'b10 or 2'b11, and at the end of the access otherwise.
- R6: On reads the early-negation flag has no effect, and chip-select stays low up to the last tick of the access.
- R7: On a read, output-enable is low exactly while chip-select is low. On a write, output-enable stays high.
- R8: On a write, write-enable lane i goes low together with chip-select only when byte enable bit i is 1. Lanes whose enable bit is 0 and all lanes on reads stay high.
- R9: A start pulse that arrives while busy is high is ignored. It changes neither the address nor the length of the running access, and it does not start a second access.
- R10: Done is high for exactly the last 4 ticks of each access, and only while busy is high.
- R11: After reset, chip-select, output-enable and all write-enables are high, and busy and done are low.
- R12: The address and write data captured at start stay steady on the memory side for the whole access. The data-drive enable is high for the whole of a write access and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four ticks per bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Access request, sampled while idle |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | BE_W | Byte enables for the write lanes |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| opt_acs | input | 2 | Chip-select delay code |
| opt_csnt | input | 1 | Early strobe negation on writes |
| opt_scy | input | 4 | Wait-state count |
| opt_relax | input | 1 | Relaxed-timing mode |
| mem_addr | output | AW | Held address to the SRAM |
| mem_wdata | output | DW | Held write data to the SRAM |
| mem_data_oe | output | 1 | Data bus drive enable during writes |
| cs_n | output | 1 | Chip-select, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | BE_W | Per-byte write-enables, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | High during the last bus clock of an access |

## Verification
A wrong tick counter or wrongly captured options move a strobe edge or the end of busy. This shows up at the first tick the strobe edge or the end of busy would have occurred, so a reference model compared on every tick catches it within a quarter bus clock. A latch that misses the busy guard shows up at once as a change on mem_addr in the middle of an access, or later as a second busy period. A wrong lane decode shows up as a write-enable edge on a lane whose enable bit is 0, at the tick chip-select falls.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;
  localparam int SCY_W   = 4;
  localparam int MAX_BUS = 4 + 2 * ((1 << SCY_W) - 1);
  localparam int TICK_W  = $clog2(4 * MAX_BUS + 1);

  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    logic             relax;
    logic [1:0]       acs;
    logic             csnt;
    logic [SCY_W-1:0] scy;
  } bank_opt_t;
endpackage

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
  import sram_strobe_pkg::*;
(
  input  bank_opt_t opt,
  input  logic      wr,
  output tick_t     cs_on,
  output tick_t     cs_off,
  output tick_t     we_off,
  output tick_t     len
);
  tick_t quarter;
  tick_t early;
  tick_t bus_n;
  tick_t scy_t;
  logic  delayed;
  logic  early_wr;

  always_comb begin
    scy_t    = tick_t'(opt.scy);
    delayed  = opt.acs[1];
    early_wr = wr & opt.csnt;
    case (opt.acs)
      2'b10:   quarter = tick_t'(1);
      2'b11:   quarter = tick_t'(2);
      default: quarter = '0;
    endcase
    cs_on = (opt.relax && delayed) ? quarter + tick_t'(4) : quarter;
    if (opt.relax)
      bus_n = tick_t'(2) + (scy_t << 1) + tick_t'(delayed) + tick_t'(early_wr);
    else
      bus_n = tick_t'(2) + scy_t;
    len = bus_n << 2;
    if (early_wr) early = opt.relax ? tick_t'(5) : tick_t'(1);
    else          early = '0;
    we_off = len - early;
    cs_off = delayed ? len - early : len;
  end
endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_strobe_pkg::*;
#(
  parameter int BE_W = 4,
  parameter int AW   = 15,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            wr,
  input  logic [BE_W-1:0] be,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  bank_opt_t       opt,
  input  tick_t           new_len,
  output logic            nxt_busy,
  output tick_t           nxt_cnt,
  output bank_opt_t       nxt_opt,
  output logic            nxt_wr,
  output logic [BE_W-1:0] nxt_be,
  output logic            busy_q,
  output logic [AW-1:0]   addr_q,
  output logic [DW-1:0]   wdata_q
);
  tick_t           cnt_q;
  tick_t           len_q;
  bank_opt_t       opt_q;
  logic            wr_q;
  logic [BE_W-1:0] be_q;
  logic            accept;

  assign accept = start & ~busy_q;

  always_comb begin
    nxt_opt = accept ? opt : opt_q;
    nxt_wr  = accept ? wr  : wr_q;
    nxt_be  = accept ? be  : be_q;
    if (accept) begin
      nxt_busy = 1'b1;
      nxt_cnt  = '0;
    end else if (busy_q) begin
      nxt_busy = (cnt_q != len_q - tick_t'(1));
      nxt_cnt  = nxt_busy ? cnt_q + tick_t'(1) : '0;
    end else begin
      nxt_busy = 1'b0;
      nxt_cnt  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      opt_q   <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      busy_q <= nxt_busy;
      cnt_q  <= nxt_cnt;
      opt_q  <= nxt_opt;
      wr_q   <= nxt_wr;
      be_q   <= nxt_be;
      if (accept) begin
        len_q   <= new_len;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/sram_strobe_drive.sv
module sram_strobe_drive
  import sram_strobe_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            nxt_busy,
  input  tick_t           nxt_cnt,
  input  logic            nxt_wr,
  input  logic [BE_W-1:0] nxt_be,
  input  tick_t           cs_on,
  input  tick_t           cs_off,
  input  tick_t           we_off,
  input  tick_t           len,
  output logic            cs_n,
  output logic            oe_n,
  output logic [BE_W-1:0] we_n,
  output logic            done,
  output logic            data_oe
);
  logic past_on;
  logic cs_win;
  logic we_win;
  logic last_bus;

  always_comb begin
    past_on  = nxt_busy && (nxt_cnt >= cs_on);
    cs_win   = past_on && (nxt_cnt < cs_off);
    we_win   = past_on && nxt_wr && (nxt_cnt < we_off);
    last_bus = nxt_busy && (nxt_cnt >= len - tick_t'(4));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n    <= 1'b1;
      oe_n    <= 1'b1;
      done    <= 1'b0;
      data_oe <= 1'b0;
    end else begin
      cs_n    <= ~cs_win;
      oe_n    <= ~(cs_win && !nxt_wr);
      done    <= last_bus;
      data_oe <= nxt_busy && nxt_wr;
    end
  end

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) we_n[g] <= 1'b1;
      else     we_n[g] <= ~(we_win && nxt_be[g]);
    end
  end
endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_strobe_pkg::*;
#(
  parameter int BE_W = 4,
  parameter int AW   = 15,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [1:0]        opt_acs,
  input  logic              opt_csnt,
  input  logic [SCY_W-1:0]  opt_scy,
  input  logic              opt_relax,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_data_oe,
  output logic              cs_n,
  output logic              oe_n,
  output logic [BE_W-1:0]   we_n,
  output logic              busy,
  output logic              done
);
  bank_opt_t       opt_in;
  bank_opt_t       nxt_opt;
  logic            nxt_busy;
  logic            nxt_wr;
  logic [BE_W-1:0] nxt_be;
  tick_t           nxt_cnt;
  tick_t           cs_on, cs_off, we_off, len;

  assign opt_in = '{relax: opt_relax, acs: opt_acs, csnt: opt_csnt, scy: opt_scy};

  sram_strobe_seq #(.BE_W(BE_W), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .be(be), .addr(addr),
    .wdata(wdata), .opt(opt_in), .new_len(len), .nxt_busy(nxt_busy),
    .nxt_cnt(nxt_cnt), .nxt_opt(nxt_opt), .nxt_wr(nxt_wr), .nxt_be(nxt_be),
    .busy_q(busy), .addr_q(mem_addr), .wdata_q(mem_wdata)
  );

  sram_strobe_decode u_dec (
    .opt(nxt_opt), .wr(nxt_wr), .cs_on(cs_on), .cs_off(cs_off),
    .we_off(we_off), .len(len)
  );

  sram_strobe_drive #(.BE_W(BE_W)) u_drv (
    .clk(clk), .rst(rst), .nxt_busy(nxt_busy), .nxt_cnt(nxt_cnt),
    .nxt_wr(nxt_wr), .nxt_be(nxt_be), .cs_on(cs_on), .cs_off(cs_off),
    .we_off(we_off), .len(len), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .done(done), .data_oe(mem_data_oe)
  );
endmodule

// File: rtl/sram_strobe_gen_checker.sv
module sram_strobe_gen_checker #(
  parameter int BE_W = 4,
  parameter int AW   = 15
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   mem_addr,
  input logic            cs_n,
  input logic            oe_n,
  input logic [BE_W-1:0] we_n,
  input logic            busy,
  input logic            done
);
  a_r11_idle_strobes_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && oe_n && (&we_n)));

  a_r7_oe_we_exclusive: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (&we_n));

  a_r8_strobes_need_cs: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !(&we_n)) |-> !cs_n);

  a_r10_done_inside_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done));

  a_r12_addr_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

bind sram_strobe_gen sram_strobe_gen_checker #(.BE_W(BE_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .cs_n(cs_n), .oe_n(oe_n),
  .we_n(we_n), .busy(busy), .done(done)
);

// File: tb/sram_strobe_gen_bench.sv
module sram_strobe_gen_bench;
  localparam int BE_W = 4;
  localparam int AW   = 15;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            wr = 1'b0;
  logic [BE_W-1:0] be = '0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [1:0]      opt_acs = '0;
  logic            opt_csnt = 1'b0;
  logic [3:0]      opt_scy = '0;
  logic            opt_relax = 1'b0;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic            mem_data_oe, cs_n, oe_n, busy, done;
  logic [BE_W-1:0] we_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sram_strobe_gen #(.BE_W(BE_W), .AW(AW), .DW(DW)) u_sram_strobe_gen (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .be(be), .addr(addr),
    .wdata(wdata), .opt_acs(opt_acs), .opt_csnt(opt_csnt), .opt_scy(opt_scy),
    .opt_relax(opt_relax), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_data_oe(mem_data_oe), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: quarter ticks since acceptance.
  bit m_busy = 0;
  int m_t, m_len, m_on, m_csend, m_weend;
  bit m_wr;
  logic [BE_W-1:0] m_be;
  logic [AW-1:0]   m_addr;
  logic [DW-1:0]   m_data;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0;
    end else if (m_busy) begin
      m_t++;
      if (m_t == m_len) m_busy = 0;
    end else if (start) begin
      int bus_clocks, shave;
      m_busy = 1; m_t = 0; m_wr = wr; m_be = be; m_addr = addr; m_data = wdata;
      m_on = (opt_acs == 2'b11) ? 2 : (opt_acs == 2'b10) ? 1 : 0;
      if (opt_relax && m_on > 0) m_on += 4;
      bus_clocks = opt_relax ? 2 + 2 * opt_scy : 2 + opt_scy;
      if (opt_relax && opt_acs[1]) bus_clocks++;
      if (opt_relax && wr && opt_csnt) bus_clocks++;
      m_len = 4 * bus_clocks;
      shave = (wr && opt_csnt) ? (opt_relax ? 5 : 1) : 0;
      m_weend = m_len - shave;
      m_csend = opt_acs[1] ? m_weend : m_len;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit a;
      a = m_busy && m_t >= m_on;
      chk(busy == m_busy, "R1 busy", busy, m_busy);
      chk(cs_n == !(a && m_t < m_csend), "R2 cs_n", cs_n, !(a && m_t < m_csend));
      chk(oe_n == !(a && !m_wr && m_t < m_len), "R7 oe_n", oe_n, !(a && !m_wr));
      for (int i = 0; i < BE_W; i++)
        chk(we_n[i] == !(a && m_wr && m_be[i] && m_t < m_weend), "R8 we_n",
            we_n[i], !(a && m_wr && m_be[i] && m_t < m_weend));
      chk(done == (m_busy && m_t >= m_len - 4), "R10 done", done, m_busy && m_t >= m_len - 4);
      chk(mem_data_oe == (m_busy && m_wr), "R12 data_oe", mem_data_oe, m_busy && m_wr);
      if (m_busy) begin
        chk(mem_addr == m_addr, "R12 addr", int'(mem_addr), int'(m_addr));
        if (m_wr) chk(mem_wdata == m_data, "R12 wdata", int'(mem_wdata), int'(m_data));
      end
    end
  end

  task automatic run_access(input bit w, input bit rx, input logic [1:0] ac,
                            input bit cn, input logic [3:0] sc, input logic [3:0] b,
                            input int e_len, input int e_on, input int e_cs, input int e_we,
                            input string len_req, input string on_req, input string off_req,
                            input bit poke);
    int t = 0, first_cs = -1, last_cs = -1, first_we = -1, last_we = -1;
    int oe_low = 0, done_cnt = 0, off_lane_low = 0;
    logic [AW-1:0] a0;
    @(negedge clk);
    wr = w; opt_relax = rx; opt_acs = ac; opt_csnt = cn; opt_scy = sc; be = b;
    addr = addr + 15'h0123; wdata = wdata ^ 32'hA5C3_0F11; start = 1'b1;
    a0 = addr;
    @(negedge clk);
    start = 1'b0;
    while (busy && t < 400) begin
      if (!cs_n) begin if (first_cs < 0) first_cs = t; last_cs = t; end
      if (!we_n[0]) begin if (first_we < 0) first_we = t; last_we = t; end
      if (!oe_n) oe_low++;
      if (done) done_cnt++;
      for (int i = 0; i < BE_W; i++) if (!b[i] && !we_n[i]) off_lane_low++;
      start = poke && (t == 3);
      if (start) addr = addr ^ 15'h7FFF;
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk(t == e_len, len_req, t, e_len);
    chk(first_cs == e_on, on_req, first_cs, e_on);
    chk(last_cs + 1 == e_cs, off_req, last_cs + 1, e_cs);
    chk(done_cnt == 4, "R10 done width", done_cnt, 4);
    chk(mem_addr == a0, "R12 held addr", int'(mem_addr), int'(a0));
    if (w) begin
      chk(oe_low == 0, "R7 oe on write", oe_low, 0);
      chk(off_lane_low == 0, "R8 disabled lanes", off_lane_low, 0);
      if (b[0]) begin
        chk(first_we == e_on, "R8 we start", first_we, e_on);
        chk(last_we + 1 == e_we, "R5 we end", last_we + 1, e_we);
      end
    end else begin
      chk(oe_low == e_len - e_on, "R7 oe on read", oe_low, e_len - e_on);
      chk(first_we < 0, "R8 we on read", first_we, -1);
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(busy == 1'b0, "R9 no second access", busy, 0);
    end
  endtask

  task automatic finish_up();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(cs_n && oe_n && (&we_n), "R11 strobes after reset", {cs_n, oe_n, we_n}, 6'h3F);
    chk(!busy && !done, "R11 busy/done after reset", {busy, done}, 0);
    //            w rx acs   cn scy be      len on cs  we
    run_access(0, 0, 2'b00, 0, 0, 4'hF,   8, 0,  8,  8, "R1", "R2", "R6", 0);
    run_access(0, 0, 2'b10, 1, 2, 4'hF,  16, 1, 16, 16, "R1", "R2", "R6", 0);
    run_access(0, 0, 2'b01, 0, 1, 4'hF,  12, 0, 12, 12, "R1", "R2", "R6", 0);
    run_access(1, 0, 2'b11, 0, 1, 4'h5,  12, 2, 12, 12, "R1", "R2", "R5", 0);
    run_access(1, 0, 2'b00, 1, 0, 4'hF,   8, 0,  8,  7, "R1", "R2", "R5", 0);
    run_access(1, 0, 2'b11, 1, 3, 4'h3,  20, 2, 19, 19, "R1", "R2", "R5", 0);
    run_access(0, 1, 2'b00, 0, 2, 4'hF,  24, 0, 24, 24, "R4", "R3", "R6", 0);
    run_access(0, 1, 2'b11, 1, 1, 4'hF,  20, 6, 20, 20, "R4", "R3", "R6", 0);
    run_access(1, 1, 2'b10, 1, 2, 4'h9,  32, 5, 27, 27, "R4", "R3", "R5", 0);
    run_access(1, 1, 2'b00, 1, 0, 4'hF,  12, 0, 12,  7, "R4", "R3", "R5", 0);
    run_access(1, 1, 2'b11, 0, 15, 4'hE, 132, 6, 132, 132, "R4", "R3", "R5", 0);
    run_access(0, 0, 2'b10, 0, 1, 4'hF,  12, 1, 12, 12, "R9", "R2", "R6", 1);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule